// File: doc/BRIEF.md
# Hardware Address Breakpoint Match Unit

This unit watches every memory, fetch and I/O access a core makes and compares it against four programmable breakpoint slots. Each slot has an address register and a small configuration field in a shared control register. The field gives the kind of access that should trigger the slot and the size of the watched region. When an access overlaps a slot's region and its kind matches, the slot's hit flag is recorded in a status register. If the slot has been armed through its local or its global enable, a one-cycle debug-exception request is also raised.

Software reaches the slot addresses, the control register and the status register through a simple register port with a select, write strobe and combinational read data. A protection bit in the control register turns any register-port access into a trap: the access is dropped, a flag is set in status, and the protection bit clears itself so that the handler can reach the registers. A task-switch pulse disarms every locally enabled slot and leaves globally enabled slots armed.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset the slot addresses and the status register read 0, the control register reads 0x0000_0400, and `trap_req` is low.
- R2: In the control register, slot n is locally enabled by bit 2n and globally enabled by bit 2n+1. Its condition sits at bits 17+4n:16+4n and its length at bits 19+4n:18+4n. Bits 0–9, 11, 13 and 16–31 are writable, bit 10 always reads 1, and bits 12, 14 and 15 read 0.
- R3: Condition 00 matches fetches, 01 matches data writes, 11 matches data reads and data writes, and 10 matches I/O only while `dbg_ext_en` is high. `acc_kind` is encoded as 00 fetch, 01 data read, 10 data write and 11 I/O.
- R4: Lengths are encoded as 00 = 1 byte, 01 = 2, 11 = 4 and 10 = 8. This applies to both the slot's length field and `acc_size`. The slot region is its address with the low 0/1/2/3 bits cleared, spanning that many bytes. A slot matches when the access's byte range overlaps that region.
- R5: A matching access sets the slot's status bit n whether or not the slot is enabled. Only a match on an enabled slot raises `trap_req`.
- R6: `trap_req` is high in exactly the cycle after the cycle that held the triggering access or register-port access.
- R7: Status bits 0–3, 13, 14, 15 and 16 are writable and all other status bits read 0. An access that traps replaces bits 3:0 with that access's match vector. A non-trapping match ORs into bits 3:0. Bits 13–16 change only by a register write or by the protection event.
- R8: While control bit 13 is set, any register-port access is suppressed: writes are dropped and read data is 0. In the following cycle `trap_req` is high, status bit 13 is 1 and control bit 13 is 0.
- R9: A `task_switch` pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged. It takes precedence over a control write in the same cycle.
- R10: Select values 0–3 address slots 0–3, 4 addresses control and 5 addresses status. Selects 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | Access length, same encoding as slot length |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 I/O |
| dbg_ext_en | input | 1 | Allows I/O-condition slots to match |
| task_switch | input | 1 | Pulse that disarms local enables |
| reg_en | input | 1 | Register-port access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| trap_req | output | 1 | One-cycle debug-exception request |

## Verification
The hardest states to reach are the ones where a register-port access is suppressed. While protection is armed, every read returns 0, so the effect of a dropped write cannot be seen until protection has cleared itself. The stimulus therefore arms protection, issues a write or a read, and checks `trap_req` in the next cycle. It then reads back the untouched slot address, the cleared control bit and the set status flag. Hits on disarmed slots, and the rule that a trap replaces status bits 3:0 while other hits OR into them, are reached by seeding status with stale flags before the access. A sweep covers every condition, length, access kind, access size and byte offset around a deliberately misaligned slot address.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int REG_W     = 32;
    localparam int MAX_SLOTS = 4;

    typedef enum logic [1:0] {
        COND_EXEC  = 2'b00,
        COND_WRITE = 2'b01,
        COND_IO    = 2'b10,
        COND_RDWR  = 2'b11
    } bp_cond_e;

    typedef enum logic [1:0] {
        LEN_1 = 2'b00,
        LEN_2 = 2'b01,
        LEN_8 = 2'b10,
        LEN_4 = 2'b11
    } bp_len_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    // slot configuration nibble: condition in the low pair, length above it
    typedef struct packed {
        bp_len_e  len;
        bp_cond_e cond;
    } slot_cfg_t;

    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;

    localparam int CTRL_PROT_BIT = 13;
    localparam int STAT_PROT_BIT = 13;
    localparam int CFG_BASE      = 16;

    localparam logic [REG_W-1:0] CTRL_WR_MASK = 32'hFFFF_2BFF;
    localparam logic [REG_W-1:0] CTRL_FIXED   = 32'h0000_0400;
    localparam logic [REG_W-1:0] CTRL_LOCAL   = 32'h0000_0055;
    localparam logic [REG_W-1:0] CTRL_GLOBAL  = 32'h0000_00AA;
    localparam logic [REG_W-1:0] STAT_WR_MASK = 32'h0001_E00F;

    // low address bits ignored for a given length code
    function automatic logic [2:0] len_mask(input bp_len_e l);
        case (l)
            LEN_1:   return 3'b000;
            LEN_2:   return 3'b001;
            LEN_4:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  slot_cfg_t         cfg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  bp_len_e           acc_size,
    input  acc_kind_e         acc_kind,
    input  logic              ext_en,
    output logic              hit
);
    logic [ADDR_W-1:0] bp_mask, acc_mask;
    logic [ADDR_W:0]   bp_lo, bp_hi, ac_lo, ac_hi;
    logic              kind_ok, overlap;

    always_comb begin
        bp_mask  = ADDR_W'(len_mask(cfg.len));
        acc_mask = ADDR_W'(len_mask(acc_size));
        // one extra bit keeps the upper ends from wrapping
        bp_lo    = {1'b0, bp_addr & ~bp_mask};
        bp_hi    = bp_lo + {1'b0, bp_mask};
        ac_lo    = {1'b0, acc_addr};
        ac_hi    = ac_lo + {1'b0, acc_mask};
        overlap  = (ac_lo <= bp_hi) && (ac_hi >= bp_lo);
    end

    always_comb begin
        case (cfg.cond)
            COND_EXEC:  kind_ok = (acc_kind == ACC_FETCH);
            COND_WRITE: kind_ok = (acc_kind == ACC_WRITE);
            COND_IO:    kind_ok = (acc_kind == ACC_IO) && ext_en;
            default:    kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
        endcase
    end

    assign hit = overlap && kind_ok;

endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_en,
    input  logic                             reg_we,
    input  logic [2:0]                       reg_sel,
    input  logic [REG_W-1:0]                 reg_wdata,
    input  logic                             task_switch,
    input  logic [NUM_SLOTS-1:0]             hit_vec,
    input  logic                             acc_trap,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr,
    output slot_cfg_t [NUM_SLOTS-1:0]        slot_cfg,
    output logic [NUM_SLOTS-1:0]             slot_en,
    output logic                             prot_evt,
    output logic [REG_W-1:0]                 reg_rdata
);
    localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [REG_W-1:0] ctrl_q, ctrl_d, stat_q, stat_d;
    logic             wr_ok, ctrl_wr;

    assign prot_evt = reg_en && ctrl_q[CTRL_PROT_BIT];
    assign wr_ok    = reg_en && reg_we && !ctrl_q[CTRL_PROT_BIT];
    assign ctrl_wr  = wr_ok && (reg_sel == SEL_CTRL);

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                bp_addr[n] <= '0;
            else if (wr_ok && reg_sel == 3'(n))
                bp_addr[n] <= reg_wdata[ADDR_W-1:0];
        end
        assign slot_en[n]  = ctrl_q[2*n] | ctrl_q[2*n+1];
        assign slot_cfg[n] = slot_cfg_t'(ctrl_q[CFG_BASE+4*n +: 4]);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr)
            ctrl_d = (reg_wdata & CTRL_WR_MASK) | CTRL_FIXED;
        if (task_switch)
            ctrl_d = ctrl_d & ~CTRL_LOCAL;
        if (prot_evt)
            ctrl_d[CTRL_PROT_BIT] = 1'b0;
    end

    always_comb begin
        stat_d = stat_q;
        if (wr_ok && reg_sel == SEL_STAT)
            stat_d = reg_wdata & STAT_WR_MASK;
        if (acc_trap)
            stat_d[NUM_SLOTS-1:0] = hit_vec;
        else
            stat_d[NUM_SLOTS-1:0] = stat_d[NUM_SLOTS-1:0] | hit_vec;
        if (prot_evt)
            stat_d[STAT_PROT_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_FIXED;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!prot_evt) begin
            if (reg_sel < 3'(NUM_SLOTS))
                reg_rdata = REG_W'(bp_addr[reg_sel[SLOT_IW-1:0]]);
            else if (reg_sel == SEL_CTRL)
                reg_rdata = ctrl_q;
            else if (reg_sel == SEL_STAT)
                reg_rdata = stat_q;
        end
    end

    AST_TASKSW_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> ((ctrl_q & CTRL_LOCAL) == '0)); // R9

    AST_TASKSW_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (task_switch && !ctrl_wr) |=> ((ctrl_q & CTRL_GLOBAL) == $past(ctrl_q & CTRL_GLOBAL))); // R9

    AST_PROT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        prot_evt |=> $stable(bp_addr)); // R8

    AST_PROT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        prot_evt |=> (stat_q[STAT_PROT_BIT] && !ctrl_q[CTRL_PROT_BIT])); // R8

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dbg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              dbg_ext_en,
    input  logic              task_switch,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              trap_req
);
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr;
    slot_cfg_t [NUM_SLOTS-1:0]        slot_cfg;
    logic [NUM_SLOTS-1:0]             slot_en, raw_hit, hit_vec;
    logic                             prot_evt, acc_trap;

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_cmp
        dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .bp_addr  (bp_addr[n]),
            .cfg      (slot_cfg[n]),
            .acc_addr (acc_addr),
            .acc_size (bp_len_e'(acc_size)),
            .acc_kind (acc_kind_e'(acc_kind)),
            .ext_en   (dbg_ext_en),
            .hit      (raw_hit[n])
        );
    end

    assign hit_vec  = raw_hit & {NUM_SLOTS{acc_valid}};
    assign acc_trap = |(hit_vec & slot_en);

    dbg_regs #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_en      (reg_en),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .task_switch (task_switch),
        .hit_vec     (hit_vec),
        .acc_trap    (acc_trap),
        .bp_addr     (bp_addr),
        .slot_cfg    (slot_cfg),
        .slot_en     (slot_en),
        .prot_evt    (prot_evt),
        .reg_rdata   (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) trap_req <= 1'b0;
        else     trap_req <= acc_trap || prot_evt;
    end

    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(acc_valid || reg_en)); // R6

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!reg_en && (raw_hit & slot_en) == '0) |=> !trap_req); // R5

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !reg_en) |=> !trap_req); // R6

endmodule

// File: tb/dbg_watch_unit_test.sv
module dbg_watch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        dbg_ext_en = 1'b0;
    logic        task_switch = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dbg_watch_unit uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .dbg_ext_en(dbg_ext_en),
        .task_switch(task_switch), .reg_en(reg_en), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] data, input bit ts = 1'b0);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = data; task_switch = ts;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; task_switch = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_sel = sel;
        #1 data = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input int sz, input int kind, output logic tr);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = 2'(sz); acc_kind = 2'(kind);
        @(negedge clk);
        acc_valid = 1'b0;
        #1 tr = trap_req;
    endtask

    function automatic longint lmask(input int l);
        case (l)
            0: return 0;
            1: return 1;
            3: return 3;
            default: return 7;
        endcase
    endfunction

    function automatic bit model_hit(input longint bp, input int cond, input int len,
                                     input int kind, input longint a, input int asz, input bit ext);
        longint bm = lmask(len);
        longint lo = bp & ~bm;
        longint hi = lo + bm;
        longint ahi = a + lmask(asz);
        bit kok;
        case (cond)
            0: kok = (kind == 0);
            1: kok = (kind == 2);
            2: kok = (kind == 3) && ext;
            default: kok = (kind == 1) || (kind == 2);
        endcase
        return kok && (a <= hi) && (ahi >= lo);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        tr;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R10: reset values through every select
        #1 check("R1 trap_req after reset", 32'(trap_req), 0);
        for (int s = 0; s < 6; s++) begin
            reg_read(3'(s), rd);
            check("R1 reset register value", rd, (s == 4) ? 32'h0000_0400 : 32'h0);
        end

        // R2: writable mask and fixed bit
        reg_write(3'd4, 32'hFFFF_DFFF);
        reg_read(3'd4, rd);
        check("R2 control mask", rd, 32'hFFFF_0FFF);
        reg_write(3'd4, 32'h0);
        reg_read(3'd4, rd);
        check("R2 bit10 held", rd, 32'h0000_0400);

        // R10: unused selects
        reg_write(3'd0, 32'h1234_5678);
        reg_write(3'd6, 32'hFFFF_FFFF);
        reg_write(3'd7, 32'hFFFF_FFFF);
        reg_read(3'd6, rd);
        check("R10 select 6 reads zero", rd, 0);
        reg_read(3'd7, rd);
        check("R10 select 7 reads zero", rd, 0);
        reg_read(3'd0, rd);
        check("R10 slot0 untouched", rd, 32'h1234_5678);

        // R9: task switch
        reg_write(3'd4, 32'h0000_00FF);
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        reg_read(3'd4, rd);
        check("R9 locals cleared", rd, 32'h0000_04AA);
        reg_write(3'd4, 32'h0000_0000);
        reg_write(3'd4, 32'h0000_00FF, 1'b1);
        reg_read(3'd4, rd);
        check("R9 switch beats write", rd, 32'h0000_04AA);

        // R7: status mask
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_read(3'd5, rd);
        check("R7 status mask", rd, 32'h0001_E00F);

        // R5 / R7 / R6: trap replaces stale flags, non-trap ORs
        reg_write(3'd0, 32'h0000_2000);
        reg_write(3'd1, 32'h0000_2000);
        reg_write(3'd4, 32'h0011_0002);
        reg_write(3'd5, 32'h0001_E00C);
        access(32'h0000_2000, 0, 2, tr);
        check("R6 trap one cycle after access", 32'(tr), 1);
        @(negedge clk); #1;
        check("R6 trap single cycle", 32'(trap_req), 0);
        reg_read(3'd5, rd);
        check("R7 trap replaces hit bits", rd, 32'h0001_E003);
        reg_write(3'd4, 32'h0011_0000);
        reg_write(3'd5, 32'h0000_0004);
        access(32'h0000_2000, 0, 2, tr);
        check("R5 disarmed slots no trap", 32'(tr), 0);
        reg_read(3'd5, rd);
        check("R7 non-trap hit ORs in", rd, 32'h0000_0007);

        // R8: protected write
        reg_write(3'd0, 32'h0000_1111);
        reg_write(3'd5, 32'h0);
        reg_write(3'd4, 32'h0000_2000);
        reg_write(3'd0, 32'h0000_2222);
        #1 check("R8 trap on protected write", 32'(trap_req), 1);
        reg_read(3'd4, rd);
        check("R8 protect bit self-clears", rd, 32'h0000_0400);
        reg_read(3'd0, rd);
        check("R8 write dropped", rd, 32'h0000_1111);
        reg_read(3'd5, rd);
        check("R8 status flag set", rd, 32'h0000_2000);
        // R8: protected read
        reg_write(3'd5, 32'h0);
        reg_write(3'd4, 32'h0000_2000);
        reg_read(3'd0, rd);
        #1 check("R8 trap on protected read", 32'(trap_req), 1);
        check("R8 protected read returns zero", rd, 0);
        reg_read(3'd5, rd);
        check("R8 status flag after read", rd, 32'h0000_2000);

        // R2 / R3 / R4 / R5 / R6 / R7: sweep one slot per configuration
        for (int c = 0; c < 4; c++) begin
            for (int l = 0; l < 4; l++) begin
                int s      = (c * 4 + l) % 4;
                int en_sel = (c * 4 + l) % 3;
                logic [31:0] bp   = 32'h0000_1000 + 32'((c + l) % 8);
                logic [31:0] ctrl = '0;
                for (int k = 0; k < 4; k++)
                    reg_write(3'(k), (k == s) ? bp : 32'h8000_0000 + 32'(k * 256));
                for (int k = 0; k < 4; k++)
                    ctrl[16 + 4 * k +: 4] = {2'(l), 2'(c)};
                if (en_sel == 1) ctrl[2 * s]     = 1'b1;
                if (en_sel == 2) ctrl[2 * s + 1] = 1'b1;
                reg_write(3'd4, ctrl);
                for (int k = 0; k < 4; k++) begin
                    for (int az = 0; az < 4; az++) begin
                        for (int d = 0; d < 24; d++) begin
                            logic [31:0] a = 32'h0000_1000 - 32'd8 + 32'(d);
                            bit ext = d[0];
                            bit m;
                            dbg_ext_en = ext;
                            m = model_hit(longint'(bp), c, l, k, longint'(a), az, ext);
                            reg_write(3'd5, 32'h0);
                            access(a, az, k, tr);
                            check("R3/R4/R5 trap vs model", 32'(tr), 32'(m && en_sel != 0));
                            reg_read(3'd5, rd);
                            check("R3/R4/R5 hit flag vs model", rd, 32'(m) << s);
                        end
                    end
                end
            end
        end
        dbg_ext_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule